// File: doc/BRIEF.md
# Banked Control-Register SPI Slave

This block lets an external host read and write a byte-wide control-register space over a four-wire serial link. The link runs in clock mode 0: the host drives SCK idle low, the block samples MOSI on each rising SCK edge, and it changes MISO after each falling edge. The block runs on its own system clock. It brings SCK, chip-select and MOSI into that clock domain through a synchronizer chain and then detects the SCK edges there.

Every transaction begins when chip-select goes low. The first byte is a command. Its upper three bits are an opcode and its lower five bits are a window address. A read command returns the selected register on MISO. A write command takes the next byte as the new value of the register. Four banks share the five-bit window. The bank comes from a bank-select field, and that field lives in a window of common registers that every bank sees. Registers of the MAC/management class place a zero filler byte ahead of their data, so a read of one of them takes three bytes instead of two.

The storage behind the window is a synchronous-read RAM for the banked registers plus a few flops for the common window. The SCK half period must be at least 6 system clocks.

Top module: `spibank_slave`

## Requirements
- R1: After reset, and at any time chip-select is high, MISO is low. All common registers reset to zero, so bank 0 is selected.
- R2: The command byte is opcode in bits [7:5] and window address in bits [4:0]. It is shifted in MSB first on rising SCK edges. MISO is shifted out MSB first and changes only after a falling SCK edge.
- R3: A read (opcode 3'b000) of an ordinary register takes 16 SCK clocks. MISO is low for the 8 command bits, then carries the register value.
- R4: A write (opcode 3'b010) takes 16 SCK clocks. The second byte is stored in the addressed register once its eighth bit has been received.
- R5: The MAC/management-class registers are bank 2 addresses 0x00–0x19 and bank 3 addresses 0x00–0x05 and 0x0A. A read of one of them takes 24 clocks: 8 command bits, then a zero filler byte, then the data. A read of any other register has no filler byte.
- R6: The bank is bits [1:0] of common register 0x1F. The same window address in different banks reaches separate storage.
- R7: Addresses 0x1B–0x1F reach the same common registers whatever bank is selected.
- R8: Bank 2 addresses 0x01 and 0x05, and address 0x1A in every bank, are reserved. A read of them returns zero, and a write to them changes nothing.
- R9: A command with any opcode other than read or write stores nothing and keeps MISO low.
- R10: If chip-select rises before the eighth data bit of a write, the write is dropped. The next transaction starts again from a fresh command byte.
- R11: A write to 0x1F changes the bank in time for the command byte of the very next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Chip-select from the host, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
A change on any SCK pin is seen inside the block one synchronizer depth plus one clock later. MISO therefore moves about three system clocks after a falling SCK edge. A read result is loaded into the output shifter three clocks after the final bit of the command byte (or of the filler byte) is detected. A write or bank change is committed one clock after its eighth data bit. The bench plays the host with an SCK half period of 8 system clocks. It samples MISO at each rising SCK edge it drives, which is at least five clocks after every change is due. Each transaction's full expected MISO stream (including the zero command and filler bytes) is queued before the transfer starts. At chip-select release it is compared with what was captured, bit count included.

// File: rtl/spibank_pkg.sv
package spibank_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int BANK_W  = 2;
  localparam int OPC_W   = 3;
  localparam int NBANK   = 1 << BANK_W;
  localparam int NWIN    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] COMMON_LO   = 5'h1B;
  localparam logic [ADDR_W-1:0] BANKSEL_ADR = 5'h1F;
  localparam int NCOMMON = NWIN - int'(COMMON_LO);
  localparam int CIDX_W  = $clog2(NCOMMON);
  localparam logic [OPC_W-1:0] OPC_RD = 3'b000;
  localparam logic [OPC_W-1:0] OPC_WR = 3'b010;

  function automatic logic is_common(input logic [ADDR_W-1:0] a);
    return a >= COMMON_LO;
  endfunction

  function automatic logic is_reserved(input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a);
    return (a == 5'h1A) || ((b == 2'd2) && ((a == 5'h01) || (a == 5'h05)));
  endfunction

  function automatic logic is_mac(input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a);
    return ((b == 2'd2) && (a < 5'h1A)) ||
           ((b == 2'd3) && ((a <= 5'h05) || (a == 5'h0A)));
  endfunction
endpackage

// File: rtl/spibank_sync_edge.sv
module spibank_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  // chain bit 2 = sck, bit 1 = csn, bit 0 = mosi
  logic [2:0] chain [STAGES];
  logic       sck_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 3'b010;
          else     chain[g] <= {sck, csn, mosi};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 3'b010;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= chain[STAGES-1][2];
  end

  assign sck_rise = chain[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~chain[STAGES-1][2] & sck_d;
  assign cs_act   = ~chain[STAGES-1][1];
  assign mosi_s   = chain[STAGES-1][0];
endmodule

// File: rtl/spibank_shifter.sv
module spibank_shifter
  import spibank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_end,
  output logic [1:0]        byte_idx,
  output logic              miso
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [1:0] BYTE_SAT = 2'd3;

  logic [BIT_W-1:0]  bit_cnt;
  logic [1:0]        byte_cnt;
  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      byte_end <= 1'b0;
      byte_idx <= '0;
      rx_byte  <= '0;
      tx_sr    <= '0;
      miso     <= 1'b0;
    end else begin
      byte_end <= 1'b0;
      if (sck_rise) begin
        rx_byte <= {rx_byte[DATA_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT && byte_cnt != BYTE_SAT) begin
          byte_end <= 1'b1;
          byte_idx <= byte_cnt;
          byte_cnt <= byte_cnt + 1'b1;
        end
      end
      if (sck_fall) miso <= tx_sr[DATA_W-1];
      if (load_en)       tx_sr <= load_byte;
      else if (sck_fall) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> ($past(sck_fall) || $past(!cs_act)));
endmodule

// File: rtl/spibank_regfile.sv
module spibank_regfile
  import spibank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [BANK_W-1:0] bank_sel
);
  localparam int DEPTH = NBANK * NWIN;
  localparam int IDX_W = BANK_W + ADDR_W;
  localparam logic [CIDX_W-1:0] BSEL_IDX = CIDX_W'(BANKSEL_ADR - COMMON_LO);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] com [NCOMMON];
  logic [DATA_W-1:0] ram_q, com_q;
  logic [IDX_W-1:0]  idx;
  logic [CIDX_W-1:0] cidx;
  logic              a_com, a_rsvd;
  logic              sel_com, sel_rsvd;

  assign idx    = {acc_bank, acc_addr};
  assign cidx   = CIDX_W'(acc_addr - COMMON_LO);
  assign a_com  = is_common(acc_addr);
  assign a_rsvd = is_reserved(acc_bank, acc_addr);

  // banked storage: one write port, registered read, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !a_rsvd && !a_com) mem[idx] <= wr_data;
    ram_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCOMMON; i++) com[i] <= '0;
      rd_valid <= 1'b0;
      sel_com  <= 1'b0;
      sel_rsvd <= 1'b0;
      com_q    <= '0;
    end else begin
      if (wr_en && !a_rsvd && a_com) com[cidx] <= wr_data;
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_com  <= a_com;
        sel_rsvd <= a_rsvd;
        com_q    <= a_com ? com[cidx] : '0;
      end
    end
  end

  assign rd_data  = sel_rsvd ? '0 : (sel_com ? com_q : ram_q);
  assign bank_sel = com[BSEL_IDX][BANK_W-1:0];

  p_bank_src_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank_sel) |-> ($past(wr_en) && $past(acc_addr) == BANKSEL_ADR));
endmodule

// File: rtl/spibank_slave.sv
module spibank_slave
  import spibank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic              sck_rise, sck_fall, cs_act, mosi_s;
  logic [DATA_W-1:0] rx_byte, rf_rd_data;
  logic              byte_end, rf_rd_valid;
  logic [1:0]        byte_idx;
  logic [BANK_W-1:0] bank_sel, acc_bank, cmd_bank;
  logic [ADDR_W-1:0] acc_addr, cmd_addr;
  logic [OPC_W-1:0]  cmd_op;
  logic              cmd_mac;
  logic              hdr_end, dat_end, new_mac, rf_rd_en, rf_wr_en, acc_rsvd;

  spibank_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spibank_shifter u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .load_en(rf_rd_valid),
    .load_byte(rf_rd_data), .rx_byte(rx_byte), .byte_end(byte_end),
    .byte_idx(byte_idx), .miso(spi_miso)
  );

  assign hdr_end  = byte_end && (byte_idx == 2'd0);
  assign dat_end  = byte_end && (byte_idx == 2'd1);
  assign new_mac  = is_mac(bank_sel, rx_byte[ADDR_W-1:0]);
  assign acc_bank = hdr_end ? bank_sel : cmd_bank;
  assign acc_addr = hdr_end ? rx_byte[ADDR_W-1:0] : cmd_addr;
  assign acc_rsvd = is_reserved(acc_bank, acc_addr);

  assign rf_rd_en = (hdr_end && rx_byte[DATA_W-1 -: OPC_W] == OPC_RD && !new_mac) ||
                    (dat_end && cmd_op == OPC_RD && cmd_mac);
  assign rf_wr_en = dat_end && cmd_op == OPC_WR;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_op   <= '1;
      cmd_addr <= '0;
      cmd_bank <= '0;
      cmd_mac  <= 1'b0;
    end else if (hdr_end) begin
      cmd_op   <= rx_byte[DATA_W-1 -: OPC_W];
      cmd_addr <= rx_byte[ADDR_W-1:0];
      cmd_bank <= bank_sel;
      cmd_mac  <= new_mac;
    end
  end

  spibank_regfile u_regs (
    .clk(clk), .rst(rst), .acc_bank(acc_bank), .acc_addr(acc_addr),
    .rd_en(rf_rd_en), .wr_en(rf_wr_en), .wr_data(rx_byte),
    .rd_valid(rf_rd_valid), .rd_data(rf_rd_data), .bank_sel(bank_sel)
  );

  p_wr_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> cs_act);

  p_load_is_read_r3: assert property (@(posedge clk) disable iff (rst)
    rf_rd_valid |-> (cmd_op == OPC_RD));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rf_rd_en && acc_rsvd) |-> (rf_rd_data == '0));

  p_odd_opc_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != OPC_RD && cmd_op != OPC_WR) |-> !rf_wr_en);
endmodule

// File: tb/spibank_slave_tb.sv
module spibank_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  int   checks = 0, bad = 0;

  always #4 clk = ~clk;

  spibank_slave u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  logic [31:0] q_exp[$];
  int          q_n[$];
  string       q_tag[$];

  logic [7:0] m_bank [4][32];
  logic [7:0] m_com  [5];
  logic [1:0] m_sel;

  function automatic logic b_rsvd(input logic [1:0] b, input logic [4:0] a);
    return (a == 5'h1A) || (b == 2'd2 && (a == 5'h01 || a == 5'h05));
  endfunction

  function automatic logic b_mac(input logic [1:0] b, input logic [4:0] a);
    return (b == 2'd2 && a <= 5'h19) || (b == 2'd3 && (a <= 5'h05 || a == 5'h0A));
  endfunction

  function automatic logic [7:0] mval(input logic [4:0] a);
    if (b_rsvd(m_sel, a)) return 8'h00;
    if (a >= 5'h1B) return m_com[a - 5'h1B];
    return m_bank[m_sel][a];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nb,
                      input logic [31:0] exp, input string tag);
    logic [23:0] s;
    s = {cmd, wd, 8'h00};
    q_exp.push_back(exp); q_n.push_back(nb); q_tag.push_back(tag);
    @(negedge clk); csn = 1'b0; tick(HALF);
    for (int i = 0; i < nb; i++) begin
      mosi = s[23-i]; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    tick(HALF); csn = 1'b1; mosi = 1'b0; tick(2*HALF);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
    xfer({3'b010, a}, d, 16, 32'h0, tag);
    if (!b_rsvd(m_sel, a)) begin
      if (a >= 5'h1B) begin
        m_com[a - 5'h1B] = d;
        if (a == 5'h1F) m_sel = d[1:0];
      end else m_bank[m_sel][a] = d;
    end
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    logic [7:0] v;
    v = mval(a);
    xfer({3'b000, a}, 8'h00, b_mac(m_sel, a) ? 24 : 16, {24'h0, v}, tag);
  endtask

  // monitor: captures MISO at every host-driven rising SCK, compares at release
  initial begin
    logic [31:0] cap, mask, exp;
    int nb, en;
    string tg;
    forever begin
      @(negedge csn);
      cap = '0; nb = 0;
      while (csn == 1'b0) begin
        @(posedge sck or posedge csn);
        if (!csn) begin cap = {cap[30:0], miso}; nb++; end
      end
      checks++;
      if (q_exp.size() == 0) begin
        bad++;
        $display("FAIL unexpected transaction actual=%0d bits expected=none", nb);
      end else begin
        exp = q_exp.pop_front(); en = q_n.pop_front(); tg = q_tag.pop_front();
        mask = (en >= 32) ? '1 : ((32'd1 << en) - 1);
        if (nb != en || (cap & mask) != exp) begin
          bad++;
          $display("FAIL %s actual=%0d bits/%h expected=%0d bits/%h", tg, nb, cap & mask, en, exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_com[i] = 8'h00;
    m_sel = 2'd0;
    tick(5); rst = 1'b0; tick(5);
    checks++;
    if (miso !== 1'b0) begin
      bad++; $display("FAIL R1 idle miso actual=%b expected=0", miso);
    end
    rd(5'h1F, "R1 bank reg resets to zero");
    wr(5'h03, 8'hC1, "R4 write bank0 0x03");
    rd(5'h03, "R3 R2 read bank0 0x03 msb first");
    wr(5'h07, 8'h96, "R4 write bank0 0x07");
    rd(5'h07, "R3 read bank0 0x07");
    wr(5'h1F, 8'h01, "R6 select bank1");
    wr(5'h03, 8'h2D, "R6 write bank1 0x03");
    rd(5'h03, "R6 read bank1 0x03");
    wr(5'h1F, 8'h00, "R6 select bank0");
    rd(5'h03, "R6 bank0 0x03 kept separate");
    wr(5'h1C, 8'h77, "R7 write common 0x1C");
    wr(5'h1F, 8'h03, "R7 select bank3");
    rd(5'h1C, "R7 common 0x1C seen in bank3");
    rd(5'h1F, "R7 bank reg read back");
    wr(5'h0A, 8'h4E, "R5 write bank3 0x0A");
    rd(5'h0A, "R5 mac-class read with filler");
    wr(5'h06, 8'h5B, "R5 write bank3 0x06");
    rd(5'h06, "R5 bank3 0x06 no filler");
    wr(5'h1F, 8'h02, "R11 select bank2");
    wr(5'h02, 8'h69, "R11 write bank2 0x02 right after select");
    rd(5'h02, "R5 bank2 0x02 read with filler");
    wr(5'h05, 8'hFF, "R8 write reserved bank2 0x05");
    rd(5'h05, "R8 reserved bank2 0x05 reads zero");
    wr(5'h1A, 8'hEE, "R8 write reserved 0x1A");
    rd(5'h1A, "R8 reserved 0x1A reads zero");
    wr(5'h1F, 8'h00, "R11 back to bank0");
    rd(5'h03, "R11 bank0 read on next transaction");
    xfer({3'b011, 5'h03}, 8'h11, 16, 32'h0, "R9 odd opcode keeps miso low");
    rd(5'h03, "R9 odd opcode stored nothing");
    xfer({3'b010, 5'h03}, 8'h33, 12, 32'h0, "R10 aborted write");
    rd(5'h03, "R10 aborted write dropped");
    wr(5'h03, 8'h3A, "R10 fresh write after abort");
    rd(5'h03, "R10 fresh write stored");
    tick(20);
    checks++;
    if (q_exp.size() != 0) begin
      bad++; $display("FAIL R2 pending items actual=%0d expected=0", q_exp.size());
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule